// File: doc/BRIEF.md
# Stepped RV32I Integer Execute Core

This block executes a reduced 32-bit RISC-V integer instruction set, one instruction per step. It owns the program counter and a 32-entry register file. Fetch happens elsewhere. For each step the surrounding logic presents one instruction word with a valid flag and pulses `step_i`. The core then resolves jumps, conditional branches, register-immediate and register-register arithmetic, word loads and word stores, and the environment call.

Data memory is reached through a request port that is active only during the step cycle. The memory side answers in the same cycle with one of three responses: hit, miss or invalid address. On a miss the instruction is not retired and the program counter stays where it is, so offering the same instruction again replays it. Illegal encodings and rejected memory accesses produce a trap record. A return through the link-and-jump-register instruction to address zero stops the core. After that, every later step is ignored.

All results are registered. They appear on the outputs in the clock cycle that follows the step edge: the program counter, a one-cycle register write-back report, trap pulses with their held record, the environment-call pulse, and the fetch-fault pulse.

Top module: `rvx_step_core`

## Requirements
- R1: After synchronous reset the program counter reads 0x0001002C and `running_o` is 1. All pulse outputs (`trap_valid_o`, `wb_valid_o`, `ecall_o`, `fetch_fault_o`) are 0.
- R2: Register-immediate operations behave as follows:
  - funct3 000 adds the sign-extended immediate.
  - funct3 010 is a signed set-less-than and funct3 011 an unsigned set-less-than.
  - funct3 100, 110 and 111 are XOR, OR and AND.
  - funct3 001 shifts left by instr[24:20].
  - funct3 101 shifts right logically when funct7 is 0000000 and arithmetically when funct7 is 0100000. Any other funct7 is illegal.
- R3: Register-register operations (opcode 0110011) shift by the low 5 bits of rs2. funct7 0000000 selects add or logical right shift, and 0100000 selects subtract or arithmetic right shift. Any other funct7 with funct3 000 or 101 is illegal.
- R4: A write to x0 is discarded and x0 always reads as zero. `wb_valid_o` reports only writes to x1..x31, with the register number and the value.
- R5: Branches use funct3 to pick the condition:
  - 000 equal and 001 not equal.
  - 100 signed less-than and 101 signed greater-or-equal.
  - 110 unsigned less-than and 111 unsigned greater-or-equal.
  A taken branch moves to PC plus the B-immediate and a not-taken branch to PC+4. funct3 010 and 011 raise an illegal trap and fall through.
- R6: JAL writes PC+4 to rd and jumps to PC plus the J-immediate. JALR writes PC+4 to rd and jumps to rs1 plus the I-immediate, computed from rs1's value before the write.
- R7: A JALR whose target is zero writes nothing, clears `running_o` and advances the PC by 4. While `running_o` is 0, steps change nothing.
- R8: LW (opcode 0000011, funct3 010) requests a read at rs1 plus the I-immediate and writes the hit data to rd. SW (opcode 0100011, funct3 010) requests a write of rs2 at rs1 plus the S-immediate. `mem_resp_i` encodes 0 as hit, 1 as miss and 2 as invalid address.
- R9: On a miss response the PC is held and no register write or trap occurs.
- R10: An invalid-address response raises a trap and advances the PC by 4. A load gives `trap_kind_o` 2 and a store gives 3. The record holds the instruction's PC, the instruction word and the memory address. For a store it also holds the store data; otherwise the data field is 0.
- R11: A SYSTEM instruction (opcode 1110011) whose I-immediate is zero pulses `ecall_o` and shows x10 on `ecall_num_o`. Other SYSTEM immediates are no-ops.
- R12: A step with `instr_valid_i` low pulses `fetch_fault_o` and leaves all architectural state unchanged.
- R13: The following raise an illegal-instruction trap (`trap_kind_o` 1, address and data fields 0) with no write, and the PC advances by 4:
  - an unknown opcode;
  - a load or store funct3 other than 010;
  - the illegal funct7 cases in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Execute one step this cycle |
| instr_valid_i | input | 1 | Instruction word is valid |
| instr_i | input | 32 | Instruction word |
| mem_req_o | output | 1 | Data memory request (combinational, step cycle) |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Data address |
| mem_wdata_o | output | 32 | Store data |
| mem_resp_i | input | 2 | 0 hit, 1 miss, 2/3 invalid address |
| mem_rdata_i | input | 32 | Load data on hit |
| pc_o | output | 32 | Program counter |
| running_o | output | 1 | Core not halted |
| fetch_fault_o | output | 1 | Step arrived without a valid instruction |
| trap_valid_o | output | 1 | Trap raised by the last step |
| trap_kind_o | output | 2 | 1 illegal, 2 bad read, 3 bad write |
| trap_pc_o | output | 32 | PC of the trapping instruction |
| trap_instr_o | output | 32 | Trapping instruction word |
| trap_addr_o | output | 32 | Faulting memory address |
| trap_data_o | output | 32 | Store data of a faulting store |
| wb_valid_o | output | 1 | A register was written |
| wb_rd_o | output | 5 | Written register number |
| wb_data_o | output | 32 | Written value |
| ecall_o | output | 1 | Environment call executed |
| ecall_num_o | output | 32 | Value of x10 at the call |

## Verification
A corrupted register file entry shows up on the outputs only when a later instruction reads that entry. It then appears as a wrong `wb_data_o`, a wrong branch outcome on `pc_o`, or a wrong memory address, all one cycle after that step. For this reason every written register is read back by a following instruction. A wrong program counter or halt flag shows on `pc_o` or `running_o` in the cycle right after the faulty step, so the bench compares those on every clock. A mishandled miss shows at once as an advanced `pc_o`, or as an unexpected write-back or trap pulse.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [2:0] F3_WORD    = 3'b010;
  localparam logic [6:0] F7_BASE    = 7'b0000000;
  localparam logic [6:0] F7_ALT     = 7'b0100000;

  typedef enum logic [1:0] {
    TRAP_NONE      = 2'd0,
    TRAP_ILLEGAL   = 2'd1,
    TRAP_BAD_READ  = 2'd2,
    TRAP_BAD_WRITE = 2'd3
  } trap_kind_e;

  typedef enum logic [1:0] {
    RESP_HIT  = 2'd0,
    RESP_MISS = 2'd1,
    RESP_BAD  = 2'd2
  } mem_resp_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;
endpackage

// File: rtl/rvx_regfile.sv
module rvx_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  // Small distributed memory: synchronous write, asynchronous read.
  logic [W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
#(
  parameter int W   = XLEN,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  shamt,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = W'($signed(a) >>> shamt);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = a + b;
    endcase
  end
endmodule

// File: rtl/rvx_branch_cmp.sv
module rvx_branch_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   cond,
  output logic         taken,
  output logic         illegal
);
  logic eq, lt_s, lt_u;
  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    illegal = 1'b0;
    unique case (cond)
      3'b000: taken = eq;
      3'b001: taken = !eq;
      3'b100: taken = lt_s;
      3'b101: taken = !lt_s;
      3'b110: taken = lt_u;
      3'b111: taken = !lt_u;
      default: begin
        taken   = 1'b0;
        illegal = 1'b1;
      end
    endcase
  end

  // R5: an unknown condition code never redirects the PC
  always_comb begin
    if (illegal === 1'b1) assert_illegal_not_taken_R5: assert (taken == 1'b0);
  end
endmodule

// File: rtl/rvx_step_core.sv
module rvx_step_core
  import rvx_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0001_002C,
  parameter int NREGS = 32,
  localparam int W  = XLEN,
  localparam int AW = $clog2(NREGS),
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          instr_valid_i,
  input  logic [31:0]   instr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  input  logic [1:0]    mem_resp_i,
  input  logic [W-1:0]  mem_rdata_i,
  output logic [W-1:0]  pc_o,
  output logic          running_o,
  output logic          fetch_fault_o,
  output logic          trap_valid_o,
  output logic [1:0]    trap_kind_o,
  output logic [W-1:0]  trap_pc_o,
  output logic [31:0]   trap_instr_o,
  output logic [W-1:0]  trap_addr_o,
  output logic [W-1:0]  trap_data_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_rd_o,
  output logic [W-1:0]  wb_data_o,
  output logic          ecall_o,
  output logic [W-1:0]  ecall_num_o
);
  // ---------------- field extraction ----------------
  logic [6:0]    opc, f7;
  logic [2:0]    f3;
  logic [AW-1:0] rd, rs1, rs2;
  logic [W-1:0]  imm_i, imm_s, imm_b, imm_j;

  assign opc = instr_i[6:0];
  assign rd  = AW'(instr_i[11:7]);
  assign f3  = instr_i[14:12];
  assign rs1 = AW'(instr_i[19:15]);
  assign rs2 = AW'(instr_i[24:20]);
  assign f7  = instr_i[31:25];
  assign imm_i = {{(W-12){instr_i[31]}}, instr_i[31:20]};
  assign imm_s = {{(W-12){instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
  assign imm_b = {{(W-13){instr_i[31]}}, instr_i[31], instr_i[7],
                  instr_i[30:25], instr_i[11:8], 1'b0};
  assign imm_j = {{(W-21){instr_i[31]}}, instr_i[31], instr_i[19:12],
                  instr_i[20], instr_i[30:21], 1'b0};

  // ---------------- architectural state ----------------
  logic [W-1:0] pc_q;
  logic         running_q;
  logic         act;
  assign act = step_i && running_q && instr_valid_i;

  logic          rf_we;
  logic [W-1:0]  rf_wdata, rs1_v, rs2_v;

  rvx_regfile #(.NREGS(NREGS), .W(W)) u_rf (
    .clk(clk), .we(act && rf_we), .waddr(rd), .wdata(rf_wdata),
    .raddr_a(rs1), .rdata_a(rs1_v), .raddr_b(rs2), .rdata_b(rs2_v)
  );

  // ---------------- ALU operand and op selection ----------------
  logic          is_reg_op, alu_bad;
  alu_op_e       alu_op;
  logic [W-1:0]  alu_b, alu_y;
  logic [SW-1:0] shamt;

  assign is_reg_op = (opc == OPC_OP);
  assign alu_b     = is_reg_op ? rs2_v : imm_i;
  assign shamt     = is_reg_op ? rs2_v[SW-1:0] : instr_i[20 +: SW];

  always_comb begin
    alu_bad = 1'b0;
    alu_op  = ALU_ADD;
    unique case (f3)
      3'b000: if (is_reg_op) begin
        if (f7 == F7_ALT) alu_op = ALU_SUB;
        else if (f7 != F7_BASE) alu_bad = 1'b1;
      end
      3'b001: alu_op = ALU_SLL;
      3'b010: alu_op = ALU_SLT;
      3'b011: alu_op = ALU_SLTU;
      3'b100: alu_op = ALU_XOR;
      3'b101: begin
        if (f7 == F7_BASE)     alu_op = ALU_SRL;
        else if (f7 == F7_ALT) alu_op = ALU_SRA;
        else                   alu_bad = 1'b1;
      end
      3'b110: alu_op = ALU_OR;
      default: alu_op = ALU_AND;
    endcase
  end

  rvx_alu #(.W(W)) u_alu (.op(alu_op), .a(rs1_v), .b(alu_b), .shamt(shamt), .y(alu_y));

  logic br_taken, br_bad;
  rvx_branch_cmp #(.W(W)) u_br (
    .a(rs1_v), .b(rs2_v), .cond(f3), .taken(br_taken), .illegal(br_bad)
  );

  // ---------------- step resolution ----------------
  logic [W-1:0] pc_plus4, next_pc, jalr_tgt;
  trap_kind_e   trap_k;
  logic [W-1:0] trap_ma, trap_md;
  logic         halt, ecall, mreq, mwe;
  mem_resp_e    resp;

  assign pc_plus4 = pc_q + W'(4);
  assign jalr_tgt = rs1_v + imm_i;
  assign resp     = (mem_resp_i == 2'd0) ? RESP_HIT :
                    (mem_resp_i == 2'd1) ? RESP_MISS : RESP_BAD;

  always_comb begin
    next_pc    = pc_plus4;
    rf_we      = 1'b0;
    rf_wdata   = alu_y;
    trap_k     = TRAP_NONE;
    trap_ma    = '0;
    trap_md    = '0;
    halt       = 1'b0;
    ecall      = 1'b0;
    mreq       = 1'b0;
    mwe        = 1'b0;
    mem_addr_o = rs1_v + imm_i;
    unique case (opc)
      OPC_JALR: begin
        if (jalr_tgt == '0) halt = 1'b1;
        else begin
          rf_we    = 1'b1;
          rf_wdata = pc_plus4;
          next_pc  = jalr_tgt;
        end
      end
      OPC_JAL: begin
        rf_we    = 1'b1;
        rf_wdata = pc_plus4;
        next_pc  = pc_q + imm_j;
      end
      OPC_BRANCH: begin
        if (br_bad)        trap_k  = TRAP_ILLEGAL;
        else if (br_taken) next_pc = pc_q + imm_b;
      end
      OPC_OPIMM, OPC_OP: begin
        if (alu_bad) trap_k = TRAP_ILLEGAL;
        else         rf_we  = 1'b1;
      end
      OPC_LOAD: begin
        if (f3 != F3_WORD) trap_k = TRAP_ILLEGAL;
        else begin
          mreq = 1'b1;
          unique case (resp)
            RESP_HIT:  begin rf_we = 1'b1; rf_wdata = mem_rdata_i; end
            RESP_MISS: next_pc = pc_q;
            default:   begin trap_k = TRAP_BAD_READ; trap_ma = mem_addr_o; end
          endcase
        end
      end
      OPC_STORE: begin
        mem_addr_o = rs1_v + imm_s;
        if (f3 != F3_WORD) trap_k = TRAP_ILLEGAL;
        else begin
          mreq = 1'b1;
          mwe  = 1'b1;
          unique case (resp)
            RESP_HIT:  ;
            RESP_MISS: next_pc = pc_q;
            default: begin
              trap_k  = TRAP_BAD_WRITE;
              trap_ma = mem_addr_o;
              trap_md = rs2_v;
            end
          endcase
        end
      end
      OPC_SYSTEM: ecall = (instr_i[31:20] == 12'd0);
      default: trap_k = TRAP_ILLEGAL;
    endcase
  end

  assign mem_req_o   = act && mreq;
  assign mem_we_o    = act && mwe;
  assign mem_wdata_o = rs2_v;

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q          <= RESET_PC;
      running_q     <= 1'b1;
      fetch_fault_o <= 1'b0;
      trap_valid_o  <= 1'b0;
      trap_kind_o   <= TRAP_NONE;
      trap_pc_o     <= '0;
      trap_instr_o  <= '0;
      trap_addr_o   <= '0;
      trap_data_o   <= '0;
      wb_valid_o    <= 1'b0;
      wb_rd_o       <= '0;
      wb_data_o     <= '0;
      ecall_o       <= 1'b0;
      ecall_num_o   <= '0;
    end else begin
      fetch_fault_o <= step_i && running_q && !instr_valid_i;
      trap_valid_o  <= 1'b0;
      wb_valid_o    <= 1'b0;
      ecall_o       <= 1'b0;
      if (act) begin
        pc_q <= next_pc;
        if (halt) running_q <= 1'b0;
        if (trap_k != TRAP_NONE) begin
          trap_valid_o <= 1'b1;
          trap_kind_o  <= trap_k;
          trap_pc_o    <= pc_q;
          trap_instr_o <= instr_i;
          trap_addr_o  <= trap_ma;
          trap_data_o  <= trap_md;
        end
        if (rf_we && rd != '0) begin
          wb_valid_o <= 1'b1;
          wb_rd_o    <= rd;
          wb_data_o  <= rf_wdata;
        end
        if (ecall) begin
          ecall_o     <= 1'b1;
          ecall_num_o <= (AW'(10) == '0) ? '0 : u_rf.mem[AW'(10)];
        end
      end
    end
  end

  assign pc_o      = pc_q;
  assign running_o = running_q;

  // ---------------- assertions ----------------
  assert_miss_holds_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_resp_i == 2'd1) |=> (pc_q == $past(pc_q)) && !trap_valid_o && !wb_valid_o);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !running_q |=> !running_q && $stable(pc_q));

  assert_fetch_fault_no_update_R12: assert property (@(posedge clk) disable iff (rst)
    (step_i && running_q && !instr_valid_i) |=> (pc_q == $past(pc_q)) && !wb_valid_o && !trap_valid_o);

  assert_bad_read_record_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o && mem_resp_i[1]) |=>
      trap_valid_o && trap_kind_o == TRAP_BAD_READ && trap_addr_o == $past(mem_addr_o));

  assert_wb_never_x0_R4: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> wb_rd_o != '0);
endmodule

// File: tb/rvx_step_core_tb_top.sv
module rvx_step_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        step_i = 0, instr_valid_i = 0;
  logic [31:0] instr_i = 0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [1:0]  mem_resp_i;
  logic [31:0] pc_o, trap_pc_o, trap_instr_o, trap_addr_o, trap_data_o, wb_data_o, ecall_num_o;
  logic        running_o, fetch_fault_o, trap_valid_o, wb_valid_o, ecall_o;
  logic [1:0]  trap_kind_o;
  logic [4:0]  wb_rd_o;

  rvx_step_core dut_i (
    .clk(clk), .rst(rst), .step_i(step_i), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_resp_i(mem_resp_i), .mem_rdata_i(mem_rdata_i), .pc_o(pc_o), .running_o(running_o),
    .fetch_fault_o(fetch_fault_o), .trap_valid_o(trap_valid_o), .trap_kind_o(trap_kind_o),
    .trap_pc_o(trap_pc_o), .trap_instr_o(trap_instr_o), .trap_addr_o(trap_addr_o),
    .trap_data_o(trap_data_o), .wb_valid_o(wb_valid_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o),
    .ecall_o(ecall_o), .ecall_num_o(ecall_num_o)
  );

  // ---------------- environment memory (window 0x200..0x2FC) ----------------
  logic [31:0] env_mem [64];
  logic        miss_inj = 0;
  function automatic logic [1:0] resp_of(input logic [31:0] a, input logic miss);
    if (miss) return 2'd1;
    if (a[31:8] == 24'h000002 && a[1:0] == 2'b00) return 2'd0;
    return 2'd2;
  endfunction
  assign mem_resp_i  = resp_of(mem_addr_o, miss_inj);
  assign mem_rdata_i = env_mem[mem_addr_o[7:2]];

  // ---------------- reference model state ----------------
  logic [31:0] m_regs [32];
  logic [31:0] m_mem  [64];
  logic [31:0] m_pc;
  logic        m_run;
  logic        e_tv, e_wv, e_ec, e_ff, e_req, e_we;
  logic [1:0]  e_tk;
  logic [31:0] e_tpc, e_tins, e_tma, e_tmd, e_wd, e_en, e_addr;
  logic [4:0]  e_wr;
  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic m_write(input logic [4:0] r, input logic [31:0] v);
    if (r != 0) begin
      m_regs[r] = v; e_wv = 1; e_wr = r; e_wd = v;
    end
  endtask

  task automatic m_trap(input logic [1:0] k, input logic [31:0] ins, input logic [31:0] ma, input logic [31:0] md);
    e_tv = 1; e_tk = k; e_tpc = m_pc; e_tins = ins; e_tma = ma; e_tmd = md;
  endtask

  task automatic model(input logic st, input logic v, input logic [31:0] ins, input logic miss);
    logic [31:0] a, b, ii, is, ib, ij, npc, t, ad;
    logic [6:0] op, f7;
    logic [2:0] f3;
    logic [4:0] rd, sh;
    logic [1:0] r;
    logic tk, bad;
    e_tv = 0; e_wv = 0; e_ec = 0; e_ff = 0; e_req = 0; e_we = 0;
    if (!st || !m_run) return;
    if (!v) begin e_ff = 1; return; end
    op = ins[6:0]; rd = ins[11:7]; f3 = ins[14:12]; f7 = ins[31:25];
    a = m_regs[ins[19:15]]; b = m_regs[ins[24:20]];
    ii = {{20{ins[31]}}, ins[31:20]};
    is = {{20{ins[31]}}, ins[31:25], ins[11:7]};
    ib = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
    ij = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
    npc = m_pc + 4;
    case (op)
      7'h67: begin
        t = a + ii;
        if (t == 0) m_run = 0; else begin m_write(rd, m_pc + 4); npc = t; end
      end
      7'h6F: begin m_write(rd, m_pc + 4); npc = m_pc + ij; end
      7'h63: begin
        bad = 0; tk = 0;
        case (f3)
          0: tk = (a == b);
          1: tk = (a != b);
          4: tk = ($signed(a) < $signed(b));
          5: tk = ($signed(a) >= $signed(b));
          6: tk = (a < b);
          7: tk = (a >= b);
          default: bad = 1;
        endcase
        if (bad) m_trap(1, ins, 0, 0);
        else if (tk) npc = m_pc + ib;
      end
      7'h13, 7'h33: begin
        if (op == 7'h33) sh = b[4:0]; else begin sh = ins[24:20]; b = ii; end
        bad = 0; t = 0;
        case (f3)
          0: if (op == 7'h13 || f7 == 0) t = a + b; else if (f7 == 7'h20) t = a - b; else bad = 1;
          1: t = a << sh;
          2: t = ($signed(a) < $signed(b)) ? 1 : 0;
          3: t = (a < b) ? 1 : 0;
          4: t = a ^ b;
          5: if (f7 == 0) t = a >> sh; else if (f7 == 7'h20) t = $signed(a) >>> sh; else bad = 1;
          6: t = a | b;
          default: t = a & b;
        endcase
        if (bad) m_trap(1, ins, 0, 0); else m_write(rd, t);
      end
      7'h03, 7'h23: begin
        if (f3 != 2) m_trap(1, ins, 0, 0);
        else begin
          ad = a + ((op == 7'h03) ? ii : is);
          r = resp_of(ad, miss);
          e_req = 1; e_we = (op == 7'h23); e_addr = ad;
          if (r == 1) npc = m_pc;
          else if (r == 0) begin
            if (op == 7'h03) m_write(rd, m_mem[ad[7:2]]); else m_mem[ad[7:2]] = b;
          end else if (op == 7'h03) m_trap(2, ins, ad, 0);
          else m_trap(3, ins, ad, b);
        end
      end
      7'h73: if (ins[31:20] == 0) begin e_ec = 1; e_en = m_regs[10]; end
      default: m_trap(1, ins, 0, 0);
    endcase
    m_pc = npc;
  endtask

  task automatic compare(input string req);
    chk(req, "pc", pc_o, m_pc);
    chk(req, "running", {31'd0, running_o}, {31'd0, m_run});
    chk(req, "fetch_fault", {31'd0, fetch_fault_o}, {31'd0, e_ff});
    chk(req, "trap_valid", {31'd0, trap_valid_o}, {31'd0, e_tv});
    if (e_tv) begin
      chk(req, "trap_kind", {30'd0, trap_kind_o}, {30'd0, e_tk});
      chk(req, "trap_pc", trap_pc_o, e_tpc);
      chk(req, "trap_instr", trap_instr_o, e_tins);
      chk(req, "trap_addr", trap_addr_o, e_tma);
      chk(req, "trap_data", trap_data_o, e_tmd);
    end
    chk(req, "wb_valid", {31'd0, wb_valid_o}, {31'd0, e_wv});
    if (e_wv) begin
      chk(req, "wb_rd", {27'd0, wb_rd_o}, {27'd0, e_wr});
      chk(req, "wb_data", wb_data_o, e_wd);
    end
    chk(req, "ecall", {31'd0, ecall_o}, {31'd0, e_ec});
    if (e_ec) chk(req, "ecall_num", ecall_num_o, e_en);
  endtask

  task automatic cyc(input string req, input logic st, input logic v, input logic [31:0] ins, input logic miss);
    logic wr_now;
    logic [31:0] wa, wd;
    @(negedge clk);
    step_i = st; instr_valid_i = v; instr_i = ins; miss_inj = miss;
    #1;
    model(st, v, ins, miss);
    if (e_req) begin
      chk(req, "mem_req", {31'd0, mem_req_o}, 32'd1);
      chk(req, "mem_we", {31'd0, mem_we_o}, {31'd0, e_we});
      chk(req, "mem_addr", mem_addr_o, e_addr);
    end else chk(req, "mem_req idle", {31'd0, mem_req_o}, 32'd0);
    wr_now = mem_req_o && mem_we_o && (mem_resp_i == 2'd0);
    wa = mem_addr_o; wd = mem_wdata_o;
    @(posedge clk);
    if (wr_now) env_mem[wa[7:2]] = wd;
    #1;
    compare(req);
  endtask

  task automatic run(input string req, input logic [31:0] ins);
    cyc(req, 1, 1, ins, 0);
  endtask

  // ---------------- encoders ----------------
  function automatic logic [31:0] ei(input logic [6:0] op, input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1, input logic [11:0] imm);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] er(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] es(input logic [2:0] f3, input logic [4:0] rs1, input logic [4:0] rs2, input logic [11:0] imm);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] eb(input logic [2:0] f3, input logic [4:0] rs1, input logic [4:0] rs2, input logic [12:0] imm);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] ej(input logic [4:0] rd, input logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6F};
  endfunction

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin env_mem[i] = 32'h1000 + i; m_mem[i] = 32'h1000 + i; end
    for (int i = 0; i < 32; i++) m_regs[i] = 0;
    m_pc = 32'h0001002C; m_run = 1;
    e_tv = 0; e_wv = 0; e_ec = 0; e_ff = 0; e_req = 0; e_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    cyc("R1", 0, 0, 0, 0);
    // R2 / R3 arithmetic
    run("R2", ei(7'h13, 0, 1, 0, 12'd5));
    run("R2", ei(7'h13, 0, 2, 0, 12'hFFD));
    run("R3", er(0, 0, 3, 1, 2));
    run("R3", er(7'h20, 0, 4, 2, 1));
    run("R3", er(0, 2, 5, 2, 1));
    run("R3", er(0, 3, 6, 2, 1));
    run("R2", ei(7'h13, 0, 12, 0, 12'd33));
    run("R3", er(7'h20, 5, 7, 2, 12));
    run("R3", er(0, 5, 8, 2, 12));
    run("R3", er(0, 1, 13, 1, 12));
    run("R3", er(0, 4, 14, 1, 2));
    run("R3", er(0, 6, 15, 1, 2));
    run("R3", er(0, 7, 16, 1, 2));
    run("R2", ei(7'h13, 2, 17, 2, 12'hFFE));
    run("R2", ei(7'h13, 3, 18, 1, 12'hFFF));
    run("R2", ei(7'h13, 3, 18, 2, 12'd1));
    run("R2", ei(7'h13, 1, 19, 2, 12'd4));
    run("R2", ei(7'h13, 5, 20, 2, 12'd28));
    run("R2", ei(7'h13, 5, 21, 2, {7'h20, 5'd1}));
    run("R2", ei(7'h13, 4, 22, 1, 12'hF0F));
    run("R2", ei(7'h13, 6, 22, 22, 12'h0F0));
    run("R2", ei(7'h13, 7, 22, 22, 12'h0FF));
    // R13 illegal encodings
    run("R13", er(7'h01, 0, 23, 1, 2));
    run("R13", er(7'h01, 5, 23, 1, 2));
    run("R13", ei(7'h13, 5, 23, 1, {7'h01, 5'd2}));
    run("R13", 32'h0000007F);
    run("R13", ei(7'h03, 0, 23, 0, 12'h200));
    run("R13", es(3'd1, 0, 1, 12'h200));
    // R4 x0
    run("R4", ei(7'h13, 0, 0, 0, 12'd9));
    run("R4", er(0, 0, 24, 0, 0));
    // R5 branches
    run("R5", eb(0, 1, 1, 13'd8));
    run("R5", eb(1, 1, 1, 13'd8));
    run("R5", eb(4, 2, 1, 13'h1FF4));
    run("R5", eb(5, 1, 1, 13'd16));
    run("R5", eb(5, 2, 1, 13'd16));
    run("R5", eb(6, 2, 1, 13'd16));
    run("R5", eb(7, 2, 1, 13'd12));
    run("R5", eb(2, 1, 1, 13'd8));
    // R6 jumps
    run("R6", ej(25, 21'd20));
    run("R6", ej(26, 21'h1FFFF8));
    run("R6", ei(7'h67, 0, 25, 25, 12'd8));
    // R8 / R9 / R10 memory
    run("R8", ei(7'h13, 0, 9, 0, 12'h200));
    run("R8", es(2, 9, 3, 12'd4));
    run("R8", ei(7'h03, 2, 27, 9, 12'd4));
    run("R8", ei(7'h03, 2, 28, 9, 12'd12));
    cyc("R9", 1, 1, es(2, 9, 4, 12'd8), 1);
    run("R9", es(2, 9, 4, 12'd8));
    cyc("R9", 1, 1, ei(7'h03, 2, 29, 9, 12'd8), 1);
    run("R9", ei(7'h03, 2, 29, 9, 12'd8));
    run("R10", ei(7'h03, 2, 30, 9, 12'hFFC));
    run("R10", es(2, 0, 1, 12'h010));
    run("R10", es(2, 9, 2, 12'd2));
    run("R4", ei(7'h03, 2, 0, 9, 12'd4));
    // R11 environment call
    run("R11", ei(7'h13, 0, 10, 0, 12'd42));
    run("R11", 32'h00000073);
    run("R11", 32'h00100073);
    // R12 fetch fault and idle cycles
    cyc("R12", 1, 0, ei(7'h13, 0, 1, 0, 12'd77), 0);
    cyc("R12", 0, 1, ei(7'h13, 0, 1, 0, 12'd77), 0);
    run("R12", er(0, 0, 31, 1, 0));
    // R7 halt
    run("R7", ei(7'h67, 0, 5, 0, 12'd0));
    run("R7", ei(7'h13, 0, 1, 0, 12'd1));
    cyc("R7", 1, 0, 0, 0);
    run("R7", er(0, 0, 31, 1, 0));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule